// File: doc/BRIEF.md
# Indexed CMOS Port Router

This block puts a two-address register window on a simple byte-wide bus. One address holds an index. The other address is a data port that reads or writes the register named by that index. Index values up to and including 0x0D belong to an external real-time-clock register file. Accesses to those values are forwarded to it over a small master port, which is itself an index/data pair. Every other index value is served from a local RAM of 256 bytes.

Writing an index in the clock range also forwards the index byte to the clock, so both sides select the same register. The local RAM resets to zero. An optional preset loads the value 20 into location 0x48 as a century byte. RAM locations 0x00 to 0x0D exist, but the data port cannot reach them, because those index values always route to the clock.

Top module: `cmos_port_router`

## Requirements
- R1: `bus_addr_i` = 0 selects the index port and `bus_addr_i` = 1 selects the data port. An access happens in a cycle where `bus_wr_i` or `bus_rd_i` is high.
- R2: A write to the index port stores all 8 bits in the select register. A later read of the index port returns that value on `bus_rdata_o` one cycle after the read.
- R3: An index write of a value of 0x0D or less drives, in the same cycle, `rtc_stb_o`=1, `rtc_we_o`=1, `rtc_addr_o`=0 and `rtc_wdata_o` equal to the byte. An index write of a value above 0x0D raises no strobe.
- R4: While the select value is 0x0D or less, a data write drives `rtc_stb_o`=1, `rtc_we_o`=1, `rtc_addr_o`=1 with the byte in the same cycle. A data read drives `rtc_stb_o`=1, `rtc_we_o`=0, `rtc_addr_o`=1, and the value on `rtc_rdata_i` in that cycle appears on `bus_rdata_o` one cycle later.
- R5: While the select value is above 0x0D, data writes store into RAM location [select] and data reads return that location. No RTC strobe is raised.
- R6: `bus_rdata_o` is registered. It changes only in the cycle after a read and holds its value otherwise.
- R7: After reset, the select register, `bus_rdata_o` and all RAM locations are zero, except the century preset.
- R8: With `CENTURY_EN`=1 (the default), RAM location 0x48 holds 20 after reset.
- R9: When `bus_wr_i` and `bus_rd_i` are high together, the access is a write only. `bus_rdata_o` keeps its value and no RTC read strobe is raised.
- R10: `rtc_stb_o` is never high in a cycle without a bus access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_addr_i | input | 1 | 0 selects the index port, 1 selects the data port |
| bus_wr_i | input | 1 | Write enable |
| bus_rd_i | input | 1 | Read enable |
| bus_wdata_i | input | 8 | Write byte |
| bus_rdata_o | output | 8 | Registered read byte |
| rtc_stb_o | output | 1 | Single-cycle RTC access strobe |
| rtc_addr_o | output | 1 | RTC port: 0 index, 1 data |
| rtc_we_o | output | 1 | RTC write qualifier |
| rtc_wdata_o | output | 8 | RTC write byte |
| rtc_rdata_i | input | 8 | RTC read byte, combinational |

## Verification
RTC strobes, mirrored index writes and forwarded data writes are due in the same cycle as the bus enable. The bench's clock stub commits them at that edge, so its state is inspected at the next falling edge. Select and RAM updates land at the edge that ends the write cycle. Read results appear on `bus_rdata_o` one edge after the read enable. Every bus task therefore drives on a falling edge, releases on the next falling edge, and samples there, which is exactly one rising edge later. Hold behaviour and the absence of strobes are checked by reading the outputs and stub counters right after the stimulus.

// File: rtl/cmos_pkg.sv
package cmos_pkg;
  typedef enum logic {
    PORT_INDEX = 1'b0,
    PORT_DATA  = 1'b1
  } port_sel_e;

  typedef enum logic [1:0] {
    SRC_SEL = 2'd0,
    SRC_RTC = 2'd1,
    SRC_RAM = 2'd2
  } rd_src_e;
endpackage

// File: rtl/cmos_sel_reg.sv
module cmos_sel_reg #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] sel_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sel_o <= '0;
    else if (wr_en_i) sel_o <= wdata_i;
  end

  // R2
  sel_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> sel_o == $past(wdata_i));
  // R2
  sel_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(sel_o));
endmodule

// File: rtl/cmos_ram.sv
module cmos_ram #(
  parameter int unsigned DW          = 8,
  parameter int unsigned DEPTH       = 256,
  parameter bit          CENTURY_EN  = 1'b1,
  parameter int unsigned CENTURY_IDX = 72,
  parameter int unsigned CENTURY_VAL = 20,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    localparam logic [DW-1:0] INIT =
      (CENTURY_EN && g == CENTURY_IDX) ? DW'(CENTURY_VAL) : '0;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                mem_q[g] <= INIT;
      else if (wr_en_i && addr_i == AW'(g))       mem_q[g] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[addr_i];

  // R5
  ram_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> mem_q[$past(addr_i)] == $past(wdata_i));
endmodule

// File: rtl/cmos_rdata_reg.sv
module cmos_rdata_reg #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ld_i,
  input  logic [DW-1:0] d_i,
  output logic [DW-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (ld_i) q_o <= d_i;
  end

  // R6
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_i |=> $stable(q_o));
endmodule

// File: rtl/cmos_port_router.sv
module cmos_port_router
  import cmos_pkg::*;
#(
  parameter int unsigned DW          = 8,
  parameter int unsigned RAM_DEPTH   = 256,
  parameter int unsigned RTC_LAST    = 13,
  parameter bit          CENTURY_EN  = 1'b1,
  parameter int unsigned CENTURY_IDX = 72,
  parameter int unsigned CENTURY_VAL = 20
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bus_addr_i,
  input  logic          bus_wr_i,
  input  logic          bus_rd_i,
  input  logic [DW-1:0] bus_wdata_i,
  output logic [DW-1:0] bus_rdata_o,
  output logic          rtc_stb_o,
  output logic          rtc_addr_o,
  output logic          rtc_we_o,
  output logic [DW-1:0] rtc_wdata_o,
  input  logic [DW-1:0] rtc_rdata_i
);
  localparam int unsigned AW = $clog2(RAM_DEPTH);
  localparam logic [DW-1:0] LAST = DW'(RTC_LAST);

  port_sel_e     port;
  logic          acc_wr, acc_rd;
  logic [DW-1:0] sel_q, ram_rdata, rd_mux;
  logic          sel_in_rtc, new_in_rtc;
  logic          sel_wr, ram_wr;
  rd_src_e       rd_src;

  assign port       = port_sel_e'(bus_addr_i);
  assign acc_wr     = bus_wr_i;
  assign acc_rd     = bus_rd_i & ~bus_wr_i;   // write wins
  assign sel_in_rtc = sel_q <= LAST;
  assign new_in_rtc = bus_wdata_i <= LAST;
  assign sel_wr     = acc_wr && port == PORT_INDEX;
  assign ram_wr     = acc_wr && port == PORT_DATA && !sel_in_rtc;

  cmos_sel_reg #(.DW(DW)) u_sel (
    .clk_i, .rst_ni, .wr_en_i(sel_wr), .wdata_i(bus_wdata_i), .sel_o(sel_q)
  );

  cmos_ram #(
    .DW(DW), .DEPTH(RAM_DEPTH), .CENTURY_EN(CENTURY_EN),
    .CENTURY_IDX(CENTURY_IDX), .CENTURY_VAL(CENTURY_VAL)
  ) u_ram (
    .clk_i, .rst_ni, .wr_en_i(ram_wr), .addr_i(sel_q[AW-1:0]),
    .wdata_i(bus_wdata_i), .rdata_o(ram_rdata)
  );

  // RTC master port
  always_comb begin
    rtc_stb_o   = 1'b0;
    rtc_addr_o  = 1'b0;
    rtc_we_o    = 1'b0;
    rtc_wdata_o = bus_wdata_i;
    if (sel_wr && new_in_rtc) begin
      rtc_stb_o = 1'b1;
      rtc_we_o  = 1'b1;
    end else if (port == PORT_DATA && sel_in_rtc && (acc_wr || acc_rd)) begin
      rtc_stb_o  = 1'b1;
      rtc_addr_o = 1'b1;
      rtc_we_o   = acc_wr;
    end
  end

  always_comb begin
    if (port == PORT_INDEX) rd_src = SRC_SEL;
    else if (sel_in_rtc)    rd_src = SRC_RTC;
    else                    rd_src = SRC_RAM;
    unique case (rd_src)
      SRC_SEL: rd_mux = sel_q;
      SRC_RTC: rd_mux = rtc_rdata_i;
      default: rd_mux = ram_rdata;
    endcase
  end

  cmos_rdata_reg #(.DW(DW)) u_rdata (
    .clk_i, .rst_ni, .ld_i(acc_rd), .d_i(rd_mux), .q_o(bus_rdata_o)
  );

  // R3
  idx_mirror_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && !bus_addr_i && bus_wdata_i <= LAST) |->
      (rtc_stb_o && rtc_we_o && !rtc_addr_o && rtc_wdata_o == bus_wdata_i));
  // R3
  idx_no_mirror_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && !bus_addr_i && bus_wdata_i > LAST) |-> !rtc_stb_o);
  // R5
  ram_no_rtc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_addr_i && sel_q > LAST) |-> !rtc_stb_o);
  // R10
  stb_needs_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rtc_stb_o |-> (bus_wr_i || bus_rd_i));
  // R9
  both_no_rtc_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && bus_rd_i) |-> !(rtc_stb_o && !rtc_we_o));
  // R2
  idx_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rd_i && !bus_wr_i && !bus_addr_i) |=> bus_rdata_o == $past(sel_q));
  // R4
  rtc_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rtc_stb_o && !rtc_we_o) |=> bus_rdata_o == $past(rtc_rdata_i));
endmodule

// File: tb/cmos_port_router_tb_top.sv
module cmos_port_router_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       addr = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       stb, raddr, rwe;
  logic [7:0] rwdata, rrdata;

  int n_chk = 0, n_fail = 0;

  // behavioural clock register stub
  logic [7:0] stub_idx = '0;
  logic [7:0] stub_mem [16];
  int         stub_idx_wr = 0, stub_dat_wr = 0, stub_rd = 0;

  always #4 clk = ~clk;

  cmos_port_router dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_wr_i(wr),
    .bus_rd_i(rd), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .rtc_stb_o(stb), .rtc_addr_o(raddr), .rtc_we_o(rwe),
    .rtc_wdata_o(rwdata), .rtc_rdata_i(rrdata)
  );

  assign rrdata = stub_mem[stub_idx[3:0]];

  always @(posedge clk) begin
    if (stb && rwe && !raddr) begin stub_idx <= rwdata; stub_idx_wr <= stub_idx_wr + 1; end
    if (stb && rwe && raddr)  begin stub_mem[stub_idx[3:0]] <= rwdata; stub_dat_wr <= stub_dat_wr + 1; end
    if (stb && !rwe)          stub_rd <= stub_rd + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_rd(input logic a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    chk(rdata == 8'h00, "R7 rdata", rdata, 0);
    bus_rd(1'b0, v); chk(v == 8'h00, "R7 select", v, 0);
    bus_rd(1'b1, v); chk(v == stub_mem[0], "R4 rtc read at select 0", v, stub_mem[0]);
    bus_wr(1'b0, 8'h20);
    bus_rd(1'b1, v); chk(v == 8'h00, "R7 ram 0x20", v, 0);
  endtask

  task automatic t_century;
    logic [7:0] v;
    bus_wr(1'b0, 8'h48);
    bus_rd(1'b1, v); chk(v == 8'd20, "R8 century", v, 20);
  endtask

  task automatic t_index;
    logic [7:0] v;
    bus_wr(1'b0, 8'hA5);
    bus_rd(1'b0, v); chk(v == 8'hA5, "R2 index readback", v, 8'hA5);
    bus_wr(1'b0, 8'h0E);
    bus_rd(1'b0, v); chk(v == 8'h0E, "R2 index readback", v, 8'h0E);
  endtask

  task automatic t_mirror;
    int c0;
    c0 = stub_idx_wr;
    bus_wr(1'b0, 8'h0D);
    chk(stub_idx == 8'h0D, "R3 mirrored index", stub_idx, 8'h0D);
    chk(stub_idx_wr == c0 + 1, "R3 mirror count", stub_idx_wr, c0 + 1);
    bus_wr(1'b0, 8'h0E);
    chk(stub_idx_wr == c0 + 1, "R3 no mirror above 0x0D", stub_idx_wr, c0 + 1);
    chk(stub_idx == 8'h0D, "R3 stub index kept", stub_idx, 8'h0D);
  endtask

  task automatic t_rtc_route;
    logic [7:0] v;
    int r0;
    bus_wr(1'b0, 8'h0D);
    bus_wr(1'b1, 8'h77);
    chk(stub_mem[13] == 8'h77, "R4 rtc data write", stub_mem[13], 8'h77);
    r0 = stub_rd;
    bus_rd(1'b1, v);
    chk(v == 8'h77, "R4 rtc data read", v, 8'h77);
    chk(stub_rd == r0 + 1, "R4 rtc read strobe", stub_rd, r0 + 1);
    bus_wr(1'b0, 8'h03);
    bus_wr(1'b1, 8'h3C);
    bus_rd(1'b1, v); chk(v == 8'h3C, "R1 R4 rtc reg 3", v, 8'h3C);
  endtask

  task automatic t_ram_route;
    logic [7:0] v;
    int w0, r0;
    w0 = stub_dat_wr; r0 = stub_rd;
    bus_wr(1'b0, 8'h0E); bus_wr(1'b1, 8'h99);
    bus_wr(1'b0, 8'hFF); bus_wr(1'b1, 8'h5B);
    bus_wr(1'b0, 8'h0E); bus_rd(1'b1, v); chk(v == 8'h99, "R5 ram 0x0E", v, 8'h99);
    bus_wr(1'b0, 8'hFF); bus_rd(1'b1, v); chk(v == 8'h5B, "R5 ram 0xFF", v, 8'h5B);
    chk(stub_dat_wr == w0, "R5 no rtc data write", stub_dat_wr, w0);
    chk(stub_rd == r0, "R5 no rtc read", stub_rd, r0);
    chk(stub_mem[13] == 8'h77, "R5 rtc reg 13 untouched", stub_mem[13], 8'h77);
  endtask

  task automatic t_hold_and_both;
    logic [7:0] v, prev;
    int r0;
    bus_wr(1'b0, 8'h0E); bus_rd(1'b1, v);
    prev = rdata;
    repeat (3) @(negedge clk);
    chk(rdata == prev, "R6 rdata holds when idle", rdata, prev);
    bus_wr(1'b1, 8'h11);
    chk(rdata == prev, "R6 rdata holds on write", rdata, prev);
    // both enables on the index port
    @(negedge clk); addr = 1'b0; wdata = 8'h30; wr = 1'b1; rd = 1'b1;
    @(negedge clk); wr = 1'b0; rd = 1'b0;
    chk(rdata == prev, "R9 rdata unchanged", rdata, prev);
    bus_rd(1'b0, v); chk(v == 8'h30, "R9 treated as write", v, 8'h30);
    // both enables on the data port with rtc select
    bus_wr(1'b0, 8'h05);
    r0 = stub_rd; prev = rdata;
    @(negedge clk); addr = 1'b1; wdata = 8'h44; wr = 1'b1; rd = 1'b1;
    @(negedge clk); wr = 1'b0; rd = 1'b0;
    chk(stub_rd == r0, "R9 no rtc read", stub_rd, r0);
    chk(rdata == prev, "R9 rdata unchanged on data port", rdata, prev);
    chk(stub_mem[5] == 8'h44, "R9 rtc data written", stub_mem[5], 8'h44);
  endtask

  task automatic t_idle_strobe;
    int n;
    n = 0;
    repeat (4) begin @(negedge clk); if (stb) n++; end
    chk(n == 0, "R10 no strobe when idle", n, 0);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) stub_mem[i] = 8'(i * 7 + 1);
    fork
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_century();
        t_index();
        t_mirror();
        t_rtc_route();
        t_ram_route();
        t_hold_and_both();
        t_idle_strobe();
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule